// File: doc/BRIEF.md
# Serial Access Port Register

This block is the serial side of a dual-port video memory. It keeps a line buffer with one 4-bit entry for each of the 256 columns of a memory row. A transfer interface either fills the whole buffer from a row or hands the whole buffer back to be written into a row. A serial clock strobe then walks a pointer through the buffer. The pointer streams entries out to the display side, or it collects entries arriving from a serial source. Each transfer can reload the pointer with a new column. If the transfer carries no column, the pointer restarts at the last column given.

The port has two organizations. In the default 4-wide organization, each serial step moves one whole entry on four lines. In the 1-wide organization, only line 0 carries data. The four bit planes of each entry go out or come in one after another, plane 0 first, before the next entry. The port switches to 1-wide once and stays there until reset. After that switch it stays silent until a transfer has re-armed its bit selector. The buffer feeds each line together with an enable, so the tri-state drivers sit outside the block.

All inputs are sampled on the rising clock edge. `sc_tick` is a single-cycle strobe that stands for one serial clock rising edge.

Top module: `sap_port`

## Requirements
- R1: After a synchronous reset, the port is in input direction in the 4-wide organization, `sout_oe` is all zero, `row_wr_en` is low, and the stored start column is 0.
- R2: A transfer with `xfer_kind` = 0 (read) copies `row_rd_data` into the buffer, with entry i taken from bits [4i+3:4i]. It sets output direction. Starting with the next cycle, `sout` shows the entry at the start column, and `sout_oe` is 4'hF while `soe_n` is low.
- R3: A transfer with `xfer_kind` = 1 (write) places the current buffer on `row_wr_data`, using the same bit layout as R2. It raises `row_wr_en` for exactly the cycle after the transfer. It also sets input direction.
- R4: A transfer with `xfer_kind` = 2 or 3 (pseudo) sets input direction. It leaves `row_wr_en` low and does not change the buffer.
- R5: A transfer with `xfer_col_valid` high loads `xfer_col` as the new start column. A transfer with `xfer_col_valid` low reuses the start column stored last. Either way, the pointer is set to that start column.
- R6: An `sc_tick` with `soe_n` low moves the pointer to the next position. While `soe_n` is high, `sc_tick` neither moves the pointer nor writes the buffer, and `sout_oe` is zero.
- R7: In input direction, an accepted `sc_tick` stores `sin` into the entry under the pointer before the pointer moves. `sout_oe` stays zero in input direction.
- R8: In the 4-wide organization, the pointer wraps from entry 255 to entry 0.
- R9: In the 1-wide organization, the pointer has 1024 positions. Position p selects entry p/4 and bit plane p mod 4. A transfer sets the pointer to 4 times the start column. Only `sout[0]`/`sout_oe[0]` are used, an accepted input tick stores `sin[0]` into that single bit, and position 1023 wraps to 0.
- R10: After `x1_set` switches the port to the 1-wide organization, `sout_oe` stays zero and ticks are ignored until the next transfer.
- R11: Once set, the 1-wide organization holds through all transfers and further `x1_set` pulses. Only reset returns the port to the 4-wide organization.
- R12: When a transfer and an `sc_tick` occur in the same cycle, the transfer wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Transfer strobe |
| xfer_kind | input | 2 | 0 read, 1 write, 2/3 pseudo |
| xfer_col_valid | input | 1 | Transfer carries a new start column |
| xfer_col | input | 8 | Start column |
| row_rd_data | input | 1024 | Row contents for a read transfer |
| row_wr_data | output | 1024 | Buffer contents handed back on a write transfer |
| row_wr_en | output | 1 | Write-back strobe, one cycle |
| x1_set | input | 1 | Switch to the 1-wide organization |
| sc_tick | input | 1 | Serial clock rising-edge strobe |
| soe_n | input | 1 | Serial enable, active low |
| sin | input | 4 | Serial input data |
| sout | output | 4 | Serial output data |
| sout_oe | output | 4 | Per-line output enable |

## Verification
A pointer that is off by one, or that wraps at the wrong place, shows up on `sout` on the first tick after the fault. The bench therefore sweeps every position of both organizations and compares each output against an arithmetic row pattern. The plane order in the 1-wide organization is checked the same way. A wrong bit order shows up within four ticks of any transfer. A direction or arming state that is wrong shows up at once on `sout_oe`. Captured input shows up only at the next write-back, so it is checked entry by entry on `row_wr_data`.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic [1:0] {
    XK_READ   = 2'd0,
    XK_WRITE  = 2'd1,
    XK_PSEUDO = 2'd2,
    XK_SPARE  = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/sap_ctrl.sv
// Direction, organization and start-column state of the serial port.
module sap_ctrl
  import sap_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_valid,
  input  logic [1:0]    xfer_kind,
  input  logic          xfer_col_valid,
  input  logic [AW-1:0] xfer_col,
  input  logic          x1_set,
  output logic          dir_out,
  output logic          mode_x1,
  output logic          sel_ok,
  output logic [AW-1:0] load_col
);
  logic [AW-1:0] start_q;

  // column used by the pointer at this transfer
  assign load_col = xfer_col_valid ? xfer_col : start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_out <= 1'b0;
      mode_x1 <= 1'b0;
      sel_ok  <= 1'b1;
      start_q <= '0;
    end else begin
      if (xfer_valid) begin
        dir_out <= (xfer_kind == XK_READ);
        sel_ok  <= 1'b1;
        if (xfer_col_valid) start_q <= xfer_col;
      end
      // switching organization disarms the bit selector until a transfer
      if (x1_set && !mode_x1) begin
        mode_x1 <= 1'b1;
        sel_ok  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sap_ptr.sv
// Serial pointer: entry index in 4-wide mode, entry/plane pair in 1-wide mode.
module sap_ptr #(
  parameter int AW = 8,
  parameter int SW = 2,
  localparam int PW = AW + SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_col,
  input  logic          step,
  input  logic          mode_x1,
  output logic [PW-1:0] ptr,
  output logic [AW-1:0] word_idx,
  output logic [SW-1:0] plane_idx
);
  logic [PW-1:0] ptr_nx;

  always_comb begin
    ptr_nx = ptr;
    if (load) begin
      ptr_nx = mode_x1 ? {load_col, {SW{1'b0}}} : {{SW{1'b0}}, load_col};
    end else if (step) begin
      ptr_nx = mode_x1 ? ptr + 1'b1
                       : {{SW{1'b0}}, (ptr[AW-1:0] + 1'b1)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else     ptr <= ptr_nx;
  end

  assign word_idx  = mode_x1 ? ptr[PW-1:SW] : ptr[AW-1:0];
  assign plane_idx = mode_x1 ? ptr[SW-1:0]  : '0;
endmodule

// File: rtl/sap_buf.sv
// Line buffer: whole-row parallel load/unload, single-entry serial access.
module sap_buf #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int SW    = $clog2(WIDTH),
  localparam int RW   = DEPTH * WIDTH
) (
  input  logic             clk,
  input  logic             row_load,
  input  logic [RW-1:0]    row_in,
  input  logic             ser_we,
  input  logic             ser_bitwise,
  input  logic [AW-1:0]    ser_word,
  input  logic [SW-1:0]    ser_plane,
  input  logic [WIDTH-1:0] ser_din,
  input  logic [AW-1:0]    rd_word,
  output logic [WIDTH-1:0] rd_data,
  output logic [RW-1:0]    row_out
);
  logic [WIDTH-1:0] rd_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [WIDTH-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (row_load) begin
        cell_q <= row_in[g*WIDTH +: WIDTH];
      end else if (ser_we && (ser_word == AW'(g))) begin
        if (ser_bitwise) cell_q[ser_plane] <= ser_din[0];
        else             cell_q <= ser_din;
      end
    end
    assign row_out[g*WIDTH +: WIDTH] = cell_q;
    assign rd_arr[g] = cell_q;
  end

  assign rd_data = rd_arr[rd_word];
endmodule

// File: rtl/sap_port.sv
// Serial access port register: line buffer, pointer and port control.
module sap_port
  import sap_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = $clog2(WIDTH),
  localparam int PW   = AW + SW,
  localparam int RW   = DEPTH * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_valid,
  input  logic [1:0]       xfer_kind,
  input  logic             xfer_col_valid,
  input  logic [AW-1:0]    xfer_col,
  input  logic [RW-1:0]    row_rd_data,
  output logic [RW-1:0]    row_wr_data,
  output logic             row_wr_en,
  input  logic             x1_set,
  input  logic             sc_tick,
  input  logic             soe_n,
  input  logic [WIDTH-1:0] sin,
  output logic [WIDTH-1:0] sout,
  output logic [WIDTH-1:0] sout_oe
);
  logic          dir_out, mode_x1, sel_ok;
  logic [AW-1:0] load_col, word_idx;
  logic [SW-1:0] plane_idx;
  logic [PW-1:0] ptr_q;
  logic [WIDTH-1:0] rd_data, sout_nx;
  logic [RW-1:0] row_out;
  logic          step, ser_we, drive_ok, is_rd, is_wr;

  assign is_rd    = xfer_valid && (xfer_kind == XK_READ);
  assign is_wr    = xfer_valid && (xfer_kind == XK_WRITE);
  // a transfer takes the cycle; a simultaneous tick is dropped
  assign step     = sc_tick && !soe_n && sel_ok && !xfer_valid;
  assign ser_we   = step && !dir_out;
  assign drive_ok = dir_out && !soe_n && sel_ok;

  sap_ctrl #(.AW(AW)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .xfer_valid    (xfer_valid),
    .xfer_kind     (xfer_kind),
    .xfer_col_valid(xfer_col_valid),
    .xfer_col      (xfer_col),
    .x1_set        (x1_set),
    .dir_out       (dir_out),
    .mode_x1       (mode_x1),
    .sel_ok        (sel_ok),
    .load_col      (load_col)
  );

  sap_ptr #(.AW(AW), .SW(SW)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (xfer_valid),
    .load_col (load_col),
    .step     (step),
    .mode_x1  (mode_x1),
    .ptr      (ptr_q),
    .word_idx (word_idx),
    .plane_idx(plane_idx)
  );

  sap_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .SW(SW)) u_buf (
    .clk        (clk),
    .row_load   (is_rd),
    .row_in     (row_rd_data),
    .ser_we     (ser_we),
    .ser_bitwise(mode_x1),
    .ser_word   (word_idx),
    .ser_plane  (plane_idx),
    .ser_din    (sin),
    .rd_word    (word_idx),
    .rd_data    (rd_data),
    .row_out    (row_out)
  );

  always_ff @(posedge clk) begin
    if (rst) row_wr_en <= 1'b0;
    else     row_wr_en <= is_wr;
  end

  always_ff @(posedge clk) begin
    if (is_wr) row_wr_data <= row_out;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_oe
    if (i == 0) begin : g_line0
      assign sout_oe[i] = drive_ok;
    end else begin : g_lineN
      assign sout_oe[i] = drive_ok && !mode_x1;
    end
  end

  always_comb begin
    sout_nx = mode_x1 ? {{(WIDTH-1){1'b0}}, rd_data[plane_idx]} : rd_data;
  end
  assign sout = sout_nx & sout_oe;
endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk
  import sap_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int PW    = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_valid,
  input logic [1:0]       xfer_kind,
  input logic             sc_tick,
  input logic             soe_n,
  input logic             row_wr_en,
  input logic [WIDTH-1:0] sout_oe,
  input logic             dir_out,
  input logic             mode_x1,
  input logic             sel_ok,
  input logic [PW-1:0]    ptr
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sout_oe == '0 && !row_wr_en));

  a_r2_read_sets_output: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_kind == XK_READ) |=> dir_out);

  a_r4_other_sets_input: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_kind != XK_READ) |=> !dir_out);

  a_r3_writeback_source: assert property (@(posedge clk) disable iff (rst)
    row_wr_en |-> $past(xfer_valid && xfer_kind == XK_WRITE));

  a_r6_ptr_holds_idle: assert property (@(posedge clk) disable iff (rst)
    (!xfer_valid && (!sc_tick || soe_n)) |=> $stable(ptr));

  a_r9_single_line: assert property (@(posedge clk) disable iff (rst)
    mode_x1 |-> (sout_oe[WIDTH-1:1] == '0));

  a_r10_unarmed_silent: assert property (@(posedge clk) disable iff (rst)
    (mode_x1 && !sel_ok) |-> (sout_oe == '0));

  a_r11_mode_sticky: assert property (@(posedge clk) disable iff (rst)
    mode_x1 |=> mode_x1);
endmodule

bind sap_port sap_port_chk #(.WIDTH(WIDTH), .PW(PW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .xfer_valid(xfer_valid),
  .xfer_kind (xfer_kind),
  .sc_tick   (sc_tick),
  .soe_n     (soe_n),
  .row_wr_en (row_wr_en),
  .sout_oe   (sout_oe),
  .dir_out   (dir_out),
  .mode_x1   (mode_x1),
  .sel_ok    (sel_ok),
  .ptr       (ptr_q)
);

// File: tb/sap_port_bench.sv
`timescale 1ns/1ps
module sap_port_bench;
  localparam int N  = 256;
  localparam int W  = 4;
  localparam int RW = N * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_valid = 1'b0;
  logic [1:0]    xfer_kind = 2'd0;
  logic          xfer_col_valid = 1'b0;
  logic [7:0]    xfer_col = 8'd0;
  logic [RW-1:0] row_rd_data = '0;
  logic [RW-1:0] row_wr_data;
  logic          row_wr_en;
  logic          x1_set = 1'b0;
  logic          sc_tick = 1'b0;
  logic          soe_n = 1'b1;
  logic [W-1:0]  sin = '0;
  logic [W-1:0]  sout, sout_oe;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  sap_port u_sap_port (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_kind(xfer_kind),
    .xfer_col_valid(xfer_col_valid), .xfer_col(xfer_col),
    .row_rd_data(row_rd_data), .row_wr_data(row_wr_data), .row_wr_en(row_wr_en),
    .x1_set(x1_set), .sc_tick(sc_tick), .soe_n(soe_n), .sin(sin),
    .sout(sout), .sout_oe(sout_oe)
  );

  function automatic int pat(int seed, int i);
    return (i * seed + 3) & 15;
  endfunction

  function automatic logic [RW-1:0] mkrow(int seed);
    logic [RW-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = 4'(pat(seed, i));
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input int kind, input bit colv, input int col);
    xfer_valid = 1'b1; xfer_kind = 2'(kind);
    xfer_col_valid = colv; xfer_col = 8'(col);
    cyc();
    xfer_valid = 1'b0; xfer_col_valid = 1'b0;
  endtask

  task automatic tick(input logic [W-1:0] d);
    sin = d; sc_tick = 1'b1;
    cyc();
    sc_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [RW-1:0] exp_row;
    repeat (4) cyc();
    rst = 1'b0;
    soe_n = 1'b0;
    cyc();
    // R1: reset state
    chk(sout_oe == 4'h0, "R1 oe", int'(sout_oe), 0);
    chk(row_wr_en == 1'b0, "R1 wr_en", int'(row_wr_en), 0);

    // R2: read transfer; R1: start column defaults to 0
    row_rd_data = mkrow(7);
    xfer(0, 1'b0, 0);
    chk(sout_oe == 4'hF, "R2 oe", int'(sout_oe), 15);
    chk(sout == 4'(pat(7, 0)), "R1/R2 first entry", int'(sout), pat(7, 0));
    // R8: full sweep with wrap back to entry 0
    for (int k = 1; k <= N; k++) begin
      tick('0);
      chk(sout == 4'(pat(7, k % N)), "R8 sweep", int'(sout), pat(7, k % N));
    end

    // R6: disabled port ignores tick and floats
    soe_n = 1'b1;
    tick('0);
    chk(sout_oe == 4'h0, "R6 oe off", int'(sout_oe), 0);
    soe_n = 1'b0;
    cyc();
    chk(sout == 4'(pat(7, 0)), "R6 ptr held", int'(sout), pat(7, 0));

    // R5: stored start column reused
    xfer(2, 1'b1, 200);
    row_rd_data = mkrow(5);
    xfer(0, 1'b0, 0);
    chk(sout == 4'(pat(5, 200)), "R5 kept column", int'(sout), pat(5, 200));
    tick('0);
    chk(sout == 4'(pat(5, 201)), "R5 step", int'(sout), pat(5, 201));

    // R12: transfer wins over tick
    sc_tick = 1'b1;
    xfer(0, 1'b1, 5);
    sc_tick = 1'b0;
    chk(sout == 4'(pat(5, 5)), "R12 tick dropped", int'(sout), pat(5, 5));

    // R4: pseudo transfer -> input direction, no write-back
    xfer(3, 1'b1, 10);
    chk(sout_oe == 4'h0, "R4 oe", int'(sout_oe), 0);
    chk(row_wr_en == 1'b0, "R4 no wr", int'(row_wr_en), 0);
    // R7: capture, with a disabled tick in the middle (R6)
    for (int k = 0; k < 8; k++) begin
      if (k == 4) begin
        soe_n = 1'b1; tick(4'hA); soe_n = 1'b0;
      end
      tick(4'((k * 3 + 1) & 15));
      chk(sout_oe == 4'h0, "R7 oe in input", int'(sout_oe), 0);
    end
    // R3: write transfer
    xfer(1, 1'b1, 10);
    chk(row_wr_en == 1'b1, "R3 wr_en", int'(row_wr_en), 1);
    exp_row = mkrow(5);
    for (int k = 0; k < 8; k++) exp_row[(10 + k)*W +: W] = 4'((k * 3 + 1) & 15);
    for (int i = 0; i < N; i++)
      chk(row_wr_data[i*W +: W] == exp_row[i*W +: W], "R3/R7 write-back",
          int'(row_wr_data[i*W +: W]), int'(exp_row[i*W +: W]));
    cyc();
    chk(row_wr_en == 1'b0, "R3 one pulse", int'(row_wr_en), 0);

    // R10: switch to 1-wide; silent until a transfer
    xfer(0, 1'b1, 0);
    chk(sout_oe == 4'hF, "R2 oe before switch", int'(sout_oe), 15);
    x1_set = 1'b1; cyc(); x1_set = 1'b0;
    chk(sout_oe == 4'h0, "R10 silent", int'(sout_oe), 0);
    tick('0);
    chk(sout_oe == 4'h0, "R10 tick ignored", int'(sout_oe), 0);

    // R9: 1-wide read, start column 3 -> position 12
    row_rd_data = mkrow(7);
    xfer(0, 1'b1, 3);
    chk(sout_oe == 4'h1, "R9 oe", int'(sout_oe), 1);
    for (int k = 0; k <= 1024; k++) begin
      int p, e;
      p = (12 + k) % 1024;
      e = (pat(7, p >> 2) >> (p & 3)) & 1;
      chk(sout == 4'(e), "R9 plane order", int'(sout), e);
      tick('0);
    end

    // R9: 1-wide capture into single bits
    xfer(2, 1'b1, 0);
    for (int k = 0; k < 8; k++) tick(4'((k * 5) & 1) | 4'hE);
    xfer(1, 1'b0, 0);
    exp_row = mkrow(7);
    for (int k = 0; k < 8; k++) exp_row[(k >> 2)*W + (k & 3)] = 1'((k * 5) & 1);
    for (int i = 0; i < 3; i++)
      chk(row_wr_data[i*W +: W] == exp_row[i*W +: W], "R9 bit capture",
          int'(row_wr_data[i*W +: W]), int'(exp_row[i*W +: W]));

    // R11: mode holds through set pulses and transfers
    x1_set = 1'b1; cyc(); x1_set = 1'b0;
    xfer(0, 1'b0, 0);
    chk(sout_oe == 4'h1, "R11 sticky", int'(sout_oe), 1);
    rst = 1'b1; cyc(); rst = 1'b0;
    chk(sout_oe == 4'h0, "R1 after reset", int'(sout_oe), 0);
    xfer(0, 1'b0, 0);
    chk(sout_oe == 4'hF, "R11 reset restores 4-wide", int'(sout_oe), 15);
    chk(sout == 4'(pat(7, 0)), "R11 column cleared", int'(sout), pat(7, 0));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule